// File: doc/BRIEF.md
# LED Port with Dimming and Light Sensing

This block is a memory-mapped output port for eight LEDs, attached to the I/O bus of a small 32-bit soft processor clocked at 30 MHz. It keeps a free-running timer that splits the clock into milliseconds and counts those milliseconds in a 32-bit word that software can read. The LEDs are dimmed by a duty gate. The stored pattern reaches the pins only in one millisecond out of every sixteen. For the rest of the time the pins either carry the charge pulse or are released.

The block also lets the LEDs act as a crude light sensor. Early in the millisecond that follows the display slot, every pin is driven high for a short window. After that window the pins go to high impedance. The level on each pin then decays at a rate that depends on the light reaching the LED. Software reads the pin levels back, after a synchronizer, through the same port word that carries the inverted switch inputs. It counts how long the pins stay high.

The processor issues I/O accesses at addresses whose bits [31:6] are all ones; bits [5:2] select a port index. Reads are combinational; writes take effect at the clock edge.

Top module: `led_light_port`

## Requirements
- R1: A cycle counter runs from 0 to CYC_PER_MS-1 (default 29999), then returns to 0. On that wrap the 32-bit millisecond count increments, and at no other edge. A read of port index 0 (address 0xFFFFFFC0) returns the millisecond count.
- R2: A write with io_wr high to port index 1 (address 0xFFFFFFC4) loads io_wdata[7:0] into the LED register at that clock edge. Writes with io_wr low, writes to any other index, and writes to non-I/O addresses leave the LED register unchanged.
- R3: While the low four bits of the millisecond count are 0, the pins are driven with the LED register.
- R4: While the low four bits of the millisecond count are 1 and cycle-counter bits [14:7] are all zero, all eight pins are driven to 0xFF.
- R5: At every other time the pins are at high impedance.
- R6: A read of port index 1 returns bits [31:16] zero, bits [15:8] the pin levels after a two-flop synchronizer, and bits [7:0] the bitwise inverse of the switch inputs.
- R7: Synchronous reset clears the LED register, both counters and the synchronizer.
- R8: A read of any other port index, or of a non-I/O address, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| io_adr | input | 32 | Byte address of the I/O access |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data for the current address |
| sw | input | 8 | Switch inputs |
| led_pad | inout | 8 | LED pins, driven or released |

## Verification
The assertions check four things on every cycle. They check the timer wrap and the millisecond increment. They check that the LED register loads only on a decoded write and holds otherwise. They check that the pins match the register in the display slot and read 0xFF in the charge window. They also check that the synchronized pin value lags the pin by exactly two edges. The bench scenarios are needed for two things the assertions cannot show. One is the pins being released everywhere else, which needs the pulled-low pin model. The other is the exact readback field layout with inverted switches, and the cycle-exact edges of the charge window at cycle counts 127 and 128.

// File: rtl/ledport_pkg.sv
package ledport_pkg;

   typedef enum logic [1:0] {
      PIN_SHOW  = 2'd0,
      PIN_FIRE  = 2'd1,
      PIN_FLOAT = 2'd2
   } pin_mode_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ledport_timer.sv
module ledport_timer #(
   parameter int unsigned CYC_PER_MS = 30000,
   parameter int unsigned CNT_W      = 15,
   parameter int unsigned MS_W       = 32
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cyc_q,
   output logic [MS_W-1:0]  ms_q
);

   localparam logic [CNT_W-1:0] CYC_MAX = CNT_W'(CYC_PER_MS - 1);

   logic wrap;
   assign wrap = (cyc_q == CYC_MAX);

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q <= '0;
         ms_q  <= '0;
      end else begin
         cyc_q <= wrap ? '0 : cyc_q + 1'b1;
         if (wrap) ms_q <= ms_q + 1'b1;
      end
   end

   // R1: wrap returns the cycle count to zero and bumps the millisecond count
   assert_cyc_wrap_R1: assert property (@(posedge clk) disable iff (rst)
      (cyc_q == CYC_MAX) |=> (cyc_q == '0 && ms_q == $past(ms_q) + MS_W'(1)));

   // R1: away from the wrap the millisecond count holds
   assert_ms_hold_R1: assert property (@(posedge clk) disable iff (rst)
      (cyc_q != CYC_MAX) |=> (ms_q == $past(ms_q) && cyc_q == $past(cyc_q) + CNT_W'(1)));

endmodule

// File: rtl/ledport_pinctl.sv
module ledport_pinctl
   import ledport_pkg::*;
#(
   parameter int unsigned LED_W    = 8,
   parameter int unsigned CNT_W    = 15,
   parameter int unsigned SLOT_W   = 4,
   parameter int unsigned FIRE_LSB = 7,
   parameter int unsigned FIRE_MSB = 14,
   parameter bit          SENSE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LED_W-1:0]  led_q,
   input  logic [CNT_W-1:0]  cyc_q,
   input  logic [SLOT_W-1:0] slot,
   output logic              drive_en,
   output logic [LED_W-1:0]  drive_val
);

   pin_mode_e mode;
   logic      fire_hit;

   generate
      if (SENSE_EN) begin : g_sense
         assign fire_hit = (slot == SLOT_W'(1)) && (cyc_q[FIRE_MSB:FIRE_LSB] == '0);
      end else begin : g_nosense
         assign fire_hit = 1'b0;
      end
   endgenerate

   logic unused_cyc;
   assign unused_cyc = ^cyc_q;

   always_comb begin
      if (slot == '0)    mode = PIN_SHOW;
      else if (fire_hit) mode = PIN_FIRE;
      else               mode = PIN_FLOAT;
   end

   assign drive_en  = (mode != PIN_FLOAT);
   assign drive_val = (mode == PIN_SHOW) ? led_q : {LED_W{1'b1}};

   // R5: pins are never driven outside the first two slots of the cycle of sixteen
   assert_drive_slots_R5: assert property (@(posedge clk) disable iff (rst)
      drive_en |-> (slot <= SLOT_W'(1)));

endmodule

// File: rtl/ledport_sync.sv
module ledport_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];

         localparam int unsigned AGE_W = $clog2(STAGES + 1);
         logic [AGE_W-1:0] age;
         always_ff @(posedge clk) begin
            if (rst) age <= '0;
            else if (age != AGE_W'(STAGES)) age <= age + 1'b1;
         end

         // R6: synchronized value is the pin value from exactly STAGES edges back
         assert_sync_lag_R6: assert property (@(posedge clk) disable iff (rst)
            (age == AGE_W'(STAGES)) |-> (q == $past(d, STAGES)));
      end
   endgenerate

endmodule

// File: rtl/led_light_port.sv
module led_light_port #(
   parameter int unsigned CYC_PER_MS  = 30000,
   parameter int unsigned MS_W        = 32,
   parameter int unsigned LED_W       = 8,
   parameter int unsigned SW_W        = 8,
   parameter int unsigned SLOT_W      = 4,
   parameter int unsigned FIRE_LSB    = 7,
   parameter int unsigned FIRE_MSB    = 14,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SENSE_EN    = 1'b1,
   parameter int unsigned MS_IDX      = 0,
   parameter int unsigned LED_IDX     = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [31:0]      io_adr,
   input  logic             io_wr,
   input  logic [31:0]      io_wdata,
   output logic [31:0]      io_rdata,
   input  logic [SW_W-1:0]  sw,
   inout  wire  [LED_W-1:0] led_pad
);

   localparam int unsigned CNT_W =
      ledport_pkg::max_u($clog2(CYC_PER_MS), FIRE_MSB + 1);

   initial begin
      assert (CYC_PER_MS >= 2) else $error("CYC_PER_MS too small");
      assert (LED_W + SW_W <= 32) else $error("readback word overflow");
      assert (MS_W <= 32 && MS_W >= SLOT_W) else $error("MS_W out of range");
      assert (FIRE_MSB >= FIRE_LSB) else $error("fire field reversed");
      assert (MS_IDX != LED_IDX && MS_IDX < 16 && LED_IDX < 16) else $error("bad port index");
   end

   logic [CNT_W-1:0] cyc_q;
   logic [MS_W-1:0]  ms_q;
   logic [LED_W-1:0] led_q;
   logic [LED_W-1:0] pad_sync;
   logic             drive_en;
   logic [LED_W-1:0] drive_val;

   logic       io_sel;
   logic [3:0] io_idx;
   logic       led_wr;

   assign io_sel = &io_adr[31:6];
   assign io_idx = io_adr[5:2];
   assign led_wr = io_wr && io_sel && (io_idx == 4'(LED_IDX));

   logic unused_bits;
   assign unused_bits = ^{io_adr[1:0], io_wdata[31:LED_W]};

   ledport_timer #(
      .CYC_PER_MS (CYC_PER_MS),
      .CNT_W      (CNT_W),
      .MS_W       (MS_W)
   ) u_timer (
      .clk   (clk),
      .rst   (rst),
      .cyc_q (cyc_q),
      .ms_q  (ms_q)
   );

   always_ff @(posedge clk) begin
      if (rst)         led_q <= '0;
      else if (led_wr) led_q <= io_wdata[LED_W-1:0];
   end

   ledport_pinctl #(
      .LED_W    (LED_W),
      .CNT_W    (CNT_W),
      .SLOT_W   (SLOT_W),
      .FIRE_LSB (FIRE_LSB),
      .FIRE_MSB (FIRE_MSB),
      .SENSE_EN (SENSE_EN)
   ) u_pinctl (
      .clk       (clk),
      .rst       (rst),
      .led_q     (led_q),
      .cyc_q     (cyc_q),
      .slot      (ms_q[SLOT_W-1:0]),
      .drive_en  (drive_en),
      .drive_val (drive_val)
   );

   assign led_pad = drive_en ? drive_val : {LED_W{1'bz}};

   ledport_sync #(
      .W      (LED_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (led_pad),
      .q   (pad_sync)
   );

   always_comb begin
      io_rdata = '0;
      if (io_sel && io_idx == 4'(MS_IDX)) begin
         io_rdata[MS_W-1:0] = ms_q;
      end else if (io_sel && io_idx == 4'(LED_IDX)) begin
         io_rdata[SW_W-1:0]      = ~sw;
         io_rdata[SW_W +: LED_W] = pad_sync;
      end
   end

   // R2: a decoded write loads the register at that edge
   assert_led_load_R2: assert property (@(posedge clk) disable iff (rst)
      led_wr |=> (led_q == $past(io_wdata[LED_W-1:0])));

   // R2: without a decoded write the register keeps its value
   assert_led_keep_R2: assert property (@(posedge clk) disable iff (rst)
      !led_wr |=> $stable(led_q));

   // R3: display slot puts the register on the pins
   assert_pad_show_R3: assert property (@(posedge clk) disable iff (rst)
      (ms_q[SLOT_W-1:0] == '0) |-> (led_pad == led_q));

   // R4: charge window drives every pin high
   assert_pad_fire_R4: assert property (@(posedge clk) disable iff (rst)
      (SENSE_EN && ms_q[SLOT_W-1:0] == SLOT_W'(1) && cyc_q[FIRE_MSB:FIRE_LSB] == '0)
      |-> (led_pad == {LED_W{1'b1}}));

endmodule

// File: tb/led_light_port_tb.sv
module led_light_port_tb;

   localparam int CYC = 400;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] adr;
   logic        wr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic [7:0]  sw;
   wire  [7:0]  pad;

   always #5 clk = ~clk;

   for (genvar g = 0; g < 8; g++) begin : g_pd
      pulldown (pad[g]);
   end

   led_light_port #(.CYC_PER_MS(CYC)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .io_adr   (adr),
      .io_wr    (wr),
      .io_wdata (wdata),
      .io_rdata (rdata),
      .sw       (sw),
      .led_pad  (pad)
   );

   int          n;
   int          checks = 0;
   int          errors = 0;
   bit          mon_en = 1'b0;
   bit          done   = 1'b0;
   logic [7:0]  led_m  = 8'h00;
   logic [7:0]  hist0  = 8'h00;
   logic [7:0]  hist1  = 8'h00;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always @(posedge clk) begin
      if (rst) n <= 0;
      else     n <= n + 1;
   end

   function automatic logic [7:0] exp_pad(input int k);
      int cyc, slot;
      cyc  = k % CYC;
      slot = (k / CYC) % 16;
      if (slot == 0) return led_m;
      if (slot == 1 && ((cyc >> 7) & 255) == 0) return 8'hFF;
      return 8'h00;
   endfunction

   function automatic string pad_tag(input int k);
      int slot;
      slot = (k / CYC) % 16;
      if (slot == 0) return "R3 display slot";
      if (slot == 1 && (((k % CYC) >> 7) & 255) == 0) return "R4 charge window";
      return "R5 released";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pins every cycle, read data popped from the scoreboard
   always @(negedge clk) begin
      if (mon_en) begin
         logic [7:0] e;
         e = exp_pad(n);
         chk(pad_tag(n), {24'h0, pad}, {24'h0, e});
         hist1 = hist0;
         hist0 = e;
         if (exp_q.size() > 0) begin
            chk(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   // driver: present a read address and push its expected value
   task automatic rd(input logic [31:0] a);
      @(negedge clk);
      #1;
      adr = a;
      if (a == 32'hFFFF_FFC4) begin
         exp_q.push_back({16'h0, hist1, ~sw});
         tag_q.push_back("R6 readback word");
      end else if (a == 32'hFFFF_FFC0) begin
         exp_q.push_back(32'((n + 1) / CYC));
         tag_q.push_back("R1 millisecond count");
      end else begin
         exp_q.push_back(32'h0);
         tag_q.push_back("R8 unmapped read");
      end
   endtask

   task automatic wr_op(input logic [31:0] a, input logic [7:0] d, input logic strobe,
                        input bit takes);
      @(negedge clk);
      #1;
      adr   = a;
      wdata = {24'hDEAD_BE, d};
      wr    = strobe;
      @(posedge clk);
      if (takes) led_m = d;
      @(negedge clk);
      chk("R2 LED register after write", {24'h0, pad}, {24'h0, exp_pad(n)});
      #1;
      wr  = 1'b0;
      adr = 32'h0;
   endtask

   task automatic read_run(input int cnt);
      for (int i = 0; i < cnt; i++) begin
         case (i % 4)
            0: rd(32'hFFFF_FFC4);
            1: rd(32'hFFFF_FFC0);
            2: rd(32'hFFFF_FFC8);
            default: rd(32'h0000_0004);
         endcase
         if (i % 1000 == 999) sw = sw + 8'h35;
      end
   endtask

   initial begin
      rst   = 1'b1;
      wr    = 1'b0;
      adr   = 32'h0;
      wdata = 32'h0;
      sw    = 8'h00;
      repeat (3) @(negedge clk);
      #1 adr = 32'hFFFF_FFC0;
      @(negedge clk);
      chk("R7 millisecond count in reset", rdata, 32'h0);
      chk("R7 pins in reset", {24'h0, pad}, 32'h0);
      #1 adr = 32'hFFFF_FFC4;
      @(negedge clk);
      chk("R7 readback in reset", rdata, 32'h0000_00FF);
      #1 rst = 1'b0;
      mon_en = 1'b1;

      wr_op(32'hFFFF_FFC4, 8'hA5, 1'b1, 1'b1);   // R2 load
      read_run(6500);
      // now in slot 0 of the next cycle of sixteen
      wr_op(32'hFFFF_FFC4, 8'h0F, 1'b0, 1'b0);   // R2 strobe low ignored
      wr_op(32'hFFFF_FFC0, 8'hFF, 1'b1, 1'b0);   // R2 other index ignored
      wr_op(32'h0000_0004, 8'hFF, 1'b1, 1'b0);   // R2 non-I/O address ignored
      wr_op(32'hFFFF_FFC4, 8'h3C, 1'b1, 1'b1);   // R2 load in display slot
      read_run(900);

      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule